// File: doc/BRIEF.md
# Load/Store Address Translation and Permission Decision Stage

This block makes the final decision for one load or store once a translation buffer has been searched. It takes the request's virtual address, its size in bytes, its direction, the current privilege mode, a flag for untranslated (physical) access and a flag marking a page-table-entry fetch. It also takes the buffer's lookup result: a hit flag, the physical page number, per-mode read and write enable masks, and the fault-on-read and fault-on-write bits. From these it produces a physical address, a fault code and a six-bit memory-status vector. The buffer and the page-table walk are not part of the block.

Faults are resolved in a fixed priority. Alignment comes first, then the physical-access bypass, then the canonical-address check, then the kernel superpage window and its mode check, then a lookup miss, then the per-mode permission test, and last the fault-on bits. A kernel superpage maps virtual to physical directly, without the buffer. Eight saturating counters keep read and write access, hit, miss and violation events apart.

Top module: `dxlat_check`

## Requirements
- R1: A request whose address AND (size-1) is nonzero, over the low four address bits, gets fault code 1 (alignment). This check wins over every other. Its status holds only bit 0 (write), which is set for stores.
- R2: A physical-access request that is aligned gets fault 0, and its physical address equals the 64-bit virtual address unchanged.
- R3: A translated request whose address bits 63:47 are not all equal gets fault 2 (violation). Its status holds bit 0 (stores only), bit 1 (violation) and bit 5 (bad address).
- R4: A canonical translated request with address bits 47:41 equal to 0x7e is a superpage access. It is allowed only in mode 0 (kernel; 1 executive, 2 supervisor, 3 user). In any other mode it gets fault 2 with status bit 0 (stores only) and bit 1.
- R5: An allowed superpage access gets fault 0. Its physical address is the virtual address bits 43:0. If bit 40 is set, bits 43:40 are forced to ones; otherwise only bits 39:0 are kept.
- R6: On a lookup miss the fault is 3, or 4 when the request is a page-table-entry fetch. The status holds bit 0 (stores only) and bit 4 (miss).
- R7: On a hit the physical address is the page number shifted left by 13, plus virtual bits 12:0. An access that passes every check gets fault 0 and status 0.
- R8: The permission bit is bit `mode` of the write mask for stores, or of the read mask for loads. If it is clear, the fault is 2 with status bit 1, plus bit 0 and bit 3 (fault-on-write set) for stores, or bit 2 (fault-on-read set) for loads.
- R9: If permission passes but the fault-on-write bit (store) or the fault-on-read bit (load) is set, the fault is 2. The status holds bit 0 and bit 3 for a store, or only bit 2 for a load.
- R10: Counters are counted separately for reads and writes. Access counts only requests that reach the buffer result, that is translated, canonical and not superpage. Hit counts any request that ends with fault 0. Miss counts faults 3 and 4. Violation counts fault 2. Alignment faults count nothing.
- R11: Each counter stops at its maximum value and does not wrap.
- R12: Results and counters update at the clock edge that captures a valid request. The response-valid output is high for exactly the cycles that follow a valid request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_va | input | 64 | Virtual address |
| req_size | input | 4 | Access size in bytes (1, 2, 4, 8) |
| req_write | input | 1 | 1 for store, 0 for load |
| req_mode | input | 2 | Current mode, 0 kernel to 3 user |
| req_phys | input | 1 | Untranslated access |
| req_pte | input | 1 | Page-table-entry fetch |
| tb_hit | input | 1 | Translation buffer hit |
| tb_ppn | input | PPN_W | Physical page number from the buffer |
| tb_rd_en | input | 4 | Per-mode read enable mask |
| tb_wr_en | input | 4 | Per-mode write enable mask |
| tb_fault_rd | input | 1 | Fault-on-read bit |
| tb_fault_wr | input | 1 | Fault-on-write bit |
| rsp_valid | output | 1 | Result valid |
| rsp_pa | output | 64 | Physical address |
| rsp_fault | output | 3 | Fault code: 0 none, 1 alignment, 2 violation, 3 miss, 4 double miss |
| rsp_status | output | 6 | Status: bit0 write, 1 violation, 2 fault-on-read, 3 fault-on-write, 4 miss, 5 bad address |
| cnt_rd_acc | output | CNT_W | Read accesses |
| cnt_rd_hit | output | CNT_W | Read hits |
| cnt_rd_miss | output | CNT_W | Read misses |
| cnt_rd_viol | output | CNT_W | Read violations |
| cnt_wr_acc | output | CNT_W | Write accesses |
| cnt_wr_hit | output | CNT_W | Write hits |
| cnt_wr_miss | output | CNT_W | Write misses |
| cnt_wr_viol | output | CNT_W | Write violations |

## Verification
The bench places a superpage at both values of bit 40. A design that kept bits 43:41 in the truncated case, or failed to fill ones in the other, returns a wrong address. Misaligned requests are sent with a bad address and with the physical flag set, so an alignment check placed after the bypass or after the canonical test shows up as a wrong fault code. Permission is exercised in modes where only the selected mask bit differs, which exposes a design that indexes the mask wrongly or reads the read mask for stores. Mixed traffic and a long run of hits check that counters for the two directions stay apart, that alignment faults stay uncounted, and that a saturated counter does not wrap to zero.

// File: rtl/dxlat_pkg.sv
package dxlat_pkg;
  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_ALIGN = 3'd1,
    FLT_VIOL  = 3'd2,
    FLT_MISS  = 3'd3,
    FLT_DMISS = 3'd4
  } flt_e;

  localparam int ST_W     = 6;
  localparam int ST_WR    = 0;
  localparam int ST_VIOL  = 1;
  localparam int ST_FONR  = 2;
  localparam int ST_FONW  = 3;
  localparam int ST_MISS  = 4;
  localparam int ST_BADVA = 5;

  localparam logic [1:0] MODE_KERNEL = 2'd0;

  // event vector layout feeding the counter bank
  localparam int EV_ACC  = 0;
  localparam int EV_HIT  = 1;
  localparam int EV_MISS = 2;
  localparam int EV_VIOL = 3;
  localparam int EV_N    = 4;
endpackage

// File: rtl/dxlat_decide.sv
module dxlat_decide
  import dxlat_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int VA_IMPL   = 48,
  parameter int PA_IMPL   = 44,
  parameter int PG_SHIFT  = 13,
  parameter int PPN_W     = 31,
  parameter logic [6:0] SP_TAG = 7'h7e
) (
  input  logic [VA_W-1:0]  va,
  input  logic [3:0]       size,
  input  logic             wr,
  input  logic [1:0]       mode,
  input  logic             phys,
  input  logic             pte,
  input  logic             hit,
  input  logic [PPN_W-1:0] ppn,
  input  logic [3:0]       rd_en,
  input  logic [3:0]       wr_en,
  input  logic             fon_rd,
  input  logic             fon_wr,
  output logic [VA_W-1:0]  pa,
  output flt_e             fault,
  output logic [ST_W-1:0]  status,
  output logic [EV_N-1:0]  ev
);
  localparam int TOP_N = VA_W - VA_IMPL + 1;
  localparam int SP_HI = VA_IMPL - 1;
  localparam int SP_LO = SP_HI - 6;

  logic [TOP_N-1:0] top_bits;
  logic             misal, canon, superpg, perm, fon_sel;
  logic [VA_W-1:0]  sp_pa, hit_pa;
  logic [PA_IMPL-1:0] sp_raw;

  assign top_bits = va[VA_W-1:VA_IMPL-1];
  assign canon    = (top_bits == '0) || (top_bits == '1);
  assign misal    = |(va[3:0] & (size - 4'd1));
  assign superpg  = (va[SP_HI:SP_LO] == SP_TAG);
  assign perm     = wr ? wr_en[mode] : rd_en[mode];
  assign fon_sel  = wr ? fon_wr : fon_rd;

  always_comb begin
    sp_raw = va[PA_IMPL-1:0];
    sp_pa  = '0;
    if (sp_raw[40]) sp_pa[PA_IMPL-1:0] = {{(PA_IMPL-40){1'b1}}, sp_raw[39:0]};
    else            sp_pa[39:0] = sp_raw[39:0];
  end

  assign hit_pa = (VA_W'(ppn) << PG_SHIFT) + VA_W'(va[PG_SHIFT-1:0]);

  always_comb begin
    fault  = FLT_NONE;
    status = '0;
    pa     = '0;
    ev     = '0;
    if (misal) begin
      fault         = FLT_ALIGN;
      status[ST_WR] = wr;
    end else if (phys) begin
      pa         = va;
      ev[EV_HIT] = 1'b1;
    end else if (!canon) begin
      fault            = FLT_VIOL;
      status[ST_WR]    = wr;
      status[ST_VIOL]  = 1'b1;
      status[ST_BADVA] = 1'b1;
      ev[EV_VIOL]      = 1'b1;
    end else if (superpg) begin
      if (mode != MODE_KERNEL) begin
        fault           = FLT_VIOL;
        status[ST_WR]   = wr;
        status[ST_VIOL] = 1'b1;
        ev[EV_VIOL]     = 1'b1;
      end else begin
        pa         = sp_pa;
        ev[EV_HIT] = 1'b1;
      end
    end else begin
      ev[EV_ACC] = 1'b1;
      if (!hit) begin
        fault           = pte ? FLT_DMISS : FLT_MISS;
        status[ST_WR]   = wr;
        status[ST_MISS] = 1'b1;
        ev[EV_MISS]     = 1'b1;
      end else begin
        pa = hit_pa;
        if (!perm || fon_sel) begin
          fault         = FLT_VIOL;
          status[ST_WR] = wr;
          ev[EV_VIOL]   = 1'b1;
          if (!perm) status[ST_VIOL] = 1'b1;
          if (wr) status[ST_FONW] = fon_wr;
          else    status[ST_FONR] = fon_rd;
        end else begin
          ev[EV_HIT] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dxlat_ctr_bank.sv
module dxlat_ctr_bank #(
  parameter int N     = 8,
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N-1:0]            inc,
  output logic [N-1:0][CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar g = 0; g < N; g++) begin : g_ctr
    always_ff @(posedge clk) begin
      if (rst)
        cnt[g] <= '0;
      else if (inc[g] && cnt[g] != CNT_MAX)
        cnt[g] <= cnt[g] + 1'b1;
    end
  end
endmodule

// File: rtl/dxlat_check.sv
module dxlat_check
  import dxlat_pkg::*;
#(
  parameter int PPN_W = 31,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [63:0]      req_va,
  input  logic [3:0]       req_size,
  input  logic             req_write,
  input  logic [1:0]       req_mode,
  input  logic             req_phys,
  input  logic             req_pte,
  input  logic             tb_hit,
  input  logic [PPN_W-1:0] tb_ppn,
  input  logic [3:0]       tb_rd_en,
  input  logic [3:0]       tb_wr_en,
  input  logic             tb_fault_rd,
  input  logic             tb_fault_wr,
  output logic             rsp_valid,
  output logic [63:0]      rsp_pa,
  output logic [2:0]       rsp_fault,
  output logic [5:0]       rsp_status,
  output logic [CNT_W-1:0] cnt_rd_acc,
  output logic [CNT_W-1:0] cnt_rd_hit,
  output logic [CNT_W-1:0] cnt_rd_miss,
  output logic [CNT_W-1:0] cnt_rd_viol,
  output logic [CNT_W-1:0] cnt_wr_acc,
  output logic [CNT_W-1:0] cnt_wr_hit,
  output logic [CNT_W-1:0] cnt_wr_miss,
  output logic [CNT_W-1:0] cnt_wr_viol
);
  localparam int NCNT = 2 * EV_N;

  logic [63:0]       d_pa;
  flt_e              d_fault;
  logic [ST_W-1:0]   d_status;
  logic [EV_N-1:0]   d_ev;
  logic [NCNT-1:0]   inc;
  logic [NCNT-1:0][CNT_W-1:0] cnt;

  dxlat_decide #(.VA_W(64), .PPN_W(PPN_W)) u_decide (
    .va(req_va), .size(req_size), .wr(req_write), .mode(req_mode),
    .phys(req_phys), .pte(req_pte), .hit(tb_hit), .ppn(tb_ppn),
    .rd_en(tb_rd_en), .wr_en(tb_wr_en), .fon_rd(tb_fault_rd),
    .fon_wr(tb_fault_wr), .pa(d_pa), .fault(d_fault),
    .status(d_status), .ev(d_ev)
  );

  assign inc = {d_ev & {EV_N{req_valid && req_write}},
                d_ev & {EV_N{req_valid && !req_write}}};

  dxlat_ctr_bank #(.N(NCNT), .CNT_W(CNT_W)) u_ctrs (
    .clk(clk), .rst(rst), .inc(inc), .cnt(cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_pa     <= '0;
      rsp_fault  <= FLT_NONE;
      rsp_status <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_pa     <= d_pa;
        rsp_fault  <= d_fault;
        rsp_status <= d_status;
      end
    end
  end

  assign cnt_rd_acc  = cnt[EV_ACC];
  assign cnt_rd_hit  = cnt[EV_HIT];
  assign cnt_rd_miss = cnt[EV_MISS];
  assign cnt_rd_viol = cnt[EV_VIOL];
  assign cnt_wr_acc  = cnt[EV_N + EV_ACC];
  assign cnt_wr_hit  = cnt[EV_N + EV_HIT];
  assign cnt_wr_miss = cnt[EV_N + EV_MISS];
  assign cnt_wr_viol = cnt[EV_N + EV_VIOL];
endmodule

// File: rtl/dxlat_check_sva.sv
module dxlat_check_sva #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             rsp_valid,
  input logic [2:0]       rsp_fault,
  input logic [5:0]       rsp_status,
  input logic [CNT_W-1:0] cnt_rd_hit,
  input logic [CNT_W-1:0] cnt_wr_viol
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  p_align_status_r1: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault == 3'd1) |-> (rsp_status[5:1] == 5'd0));

  p_badva_is_viol_r3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status[5]) |-> (rsp_fault == 3'd2 && rsp_status[1]));

  p_miss_flags_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_fault == 3'd3 || rsp_fault == 3'd4))
      |-> (rsp_status[4] && rsp_status[3:1] == 3'd0 && !rsp_status[5]));

  p_clean_hit_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault == 3'd0) |-> (rsp_status == 6'd0));

  p_no_wrap_r11: assert property (@(posedge clk) disable iff (rst)
    (cnt_rd_hit == MAXV) |=> (cnt_rd_hit == MAXV));

  p_monotonic_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cnt_wr_viol >= $past(cnt_wr_viol)));

  p_rsp_follows_r12: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  p_rsp_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
endmodule

bind dxlat_check dxlat_check_sva #(.CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst(rst), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_fault(rsp_fault), .rsp_status(rsp_status),
  .cnt_rd_hit(cnt_rd_hit), .cnt_wr_viol(cnt_wr_viol)
);

// File: tb/sim_dxlat_check.sv
module sim_dxlat_check;
  localparam int CLK_PERIOD = 10;
  localparam int PPN_W = 31;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rst;
  logic req_valid, req_write, req_phys, req_pte;
  logic [63:0] req_va;
  logic [3:0]  req_size;
  logic [1:0]  req_mode;
  logic tb_hit, tb_fault_rd, tb_fault_wr;
  logic [PPN_W-1:0] tb_ppn;
  logic [3:0] tb_rd_en, tb_wr_en;
  logic rsp_valid;
  logic [63:0] rsp_pa;
  logic [2:0] rsp_fault;
  logic [5:0] rsp_status;
  logic [CNT_W-1:0] cnt_rd_acc, cnt_rd_hit, cnt_rd_miss, cnt_rd_viol;
  logic [CNT_W-1:0] cnt_wr_acc, cnt_wr_hit, cnt_wr_miss, cnt_wr_viol;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dxlat_check #(.PPN_W(PPN_W), .CNT_W(CNT_W)) u0 (.*);

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic set_tb(input logic hit, input logic [PPN_W-1:0] ppn,
                        input logic [3:0] re, input logic [3:0] we,
                        input logic fr, input logic fw);
    tb_hit = hit; tb_ppn = ppn; tb_rd_en = re; tb_wr_en = we;
    tb_fault_rd = fr; tb_fault_wr = fw;
  endtask

  task automatic issue(input logic [63:0] va, input logic [3:0] sz,
                       input logic wr, input logic [1:0] md,
                       input logic ph, input logic pt);
    @(negedge clk);
    req_va = va; req_size = sz; req_write = wr; req_mode = md;
    req_phys = ph; req_pte = pt; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R12", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    chk("R10", "rd_hit after reset", 64'(cnt_rd_hit), 64'd0);
    chk("R10", "wr_viol after reset", 64'(cnt_wr_viol), 64'd0);
  endtask

  task automatic t_align();
    set_tb(1'b1, 31'h5, 4'hf, 4'hf, 1'b0, 1'b0);
    issue(64'h0001_0000_0000_0004, 4'd8, 1'b1, 2'd3, 1'b0, 1'b0);
    chk("R1", "valid", 64'(rsp_valid), 64'd1);
    chk("R1", "fault store bad-va misaligned", 64'(rsp_fault), 64'd1);
    chk("R1", "status store", 64'(rsp_status), 64'h01);
    issue(64'h0000_0000_0000_0002, 4'd4, 1'b0, 2'd0, 1'b1, 1'b0);
    chk("R1", "fault phys load misaligned", 64'(rsp_fault), 64'd1);
    chk("R1", "status load", 64'(rsp_status), 64'h00);
    @(negedge clk);
    chk("R12", "valid drops after idle", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_phys();
    issue(64'h0001_2345_6789_ABC8, 4'd8, 1'b0, 2'd3, 1'b1, 1'b0);
    chk("R2", "fault", 64'(rsp_fault), 64'd0);
    chk("R2", "pa", rsp_pa, 64'h0001_2345_6789_ABC8);
  endtask

  task automatic t_badva();
    issue(64'h0001_0000_0000_0000, 4'd1, 1'b1, 2'd0, 1'b0, 1'b0);
    chk("R3", "fault", 64'(rsp_fault), 64'd2);
    chk("R3", "status", 64'(rsp_status), 64'h23);
  endtask

  task automatic t_superpage();
    issue(64'hFFFF_FC00_1234_5678, 4'd4, 1'b0, 2'd0, 1'b0, 1'b0);
    chk("R5", "fault kernel", 64'(rsp_fault), 64'd0);
    chk("R5", "pa bit40 clear", rsp_pa, 64'h0000_0000_1234_5678);
    issue(64'hFFFF_FD00_0000_1000, 4'd8, 1'b1, 2'd0, 1'b0, 1'b0);
    chk("R5", "pa bit40 set", rsp_pa, 64'h0000_0F00_0000_1000);
    issue(64'hFFFF_FC00_1234_5678, 4'd4, 1'b0, 2'd3, 1'b0, 1'b0);
    chk("R4", "fault user", 64'(rsp_fault), 64'd2);
    chk("R4", "status load", 64'(rsp_status), 64'h02);
    issue(64'hFFFF_FC00_1234_5678, 4'd4, 1'b1, 2'd1, 1'b0, 1'b0);
    chk("R4", "status store", 64'(rsp_status), 64'h03);
  endtask

  task automatic t_miss();
    set_tb(1'b0, 31'h0, 4'hf, 4'hf, 1'b0, 1'b0);
    issue(64'h0000_0000_0040_0000, 4'd8, 1'b1, 2'd0, 1'b0, 1'b0);
    chk("R6", "fault", 64'(rsp_fault), 64'd3);
    chk("R6", "status store", 64'(rsp_status), 64'h11);
    issue(64'h0000_0000_0040_0000, 4'd8, 1'b0, 2'd0, 1'b0, 1'b1);
    chk("R6", "fault pte", 64'(rsp_fault), 64'd4);
    chk("R6", "status load", 64'(rsp_status), 64'h10);
  endtask

  task automatic t_hit();
    logic [PPN_W-1:0] p;
    logic [63:0] va;
    p  = 31'h1ABCD;
    va = 64'h0000_0000_0077_1F0C;
    set_tb(1'b1, p, 4'hf, 4'hf, 1'b0, 1'b0);
    issue(va, 4'd4, 1'b0, 2'd3, 1'b0, 1'b0);
    chk("R7", "fault", 64'(rsp_fault), 64'd0);
    chk("R7", "status", 64'(rsp_status), 64'd0);
    chk("R7", "pa", rsp_pa, ({33'd0, p} << 13) | {51'd0, va[12:0]});
  endtask

  task automatic t_perm();
    set_tb(1'b1, 31'h10, 4'b0100, 4'b0010, 1'b1, 1'b1);
    issue(64'h0000_0000_0000_2000, 4'd1, 1'b0, 2'd1, 1'b0, 1'b0);
    chk("R8", "load mode1 fault", 64'(rsp_fault), 64'd2);
    chk("R8", "load status", 64'(rsp_status), 64'h06);
    issue(64'h0000_0000_0000_2000, 4'd1, 1'b1, 2'd2, 1'b0, 1'b0);
    chk("R8", "store mode2 status", 64'(rsp_status), 64'h0B);
    set_tb(1'b1, 31'h10, 4'b0100, 4'b0010, 1'b0, 1'b0);
    issue(64'h0000_0000_0000_2000, 4'd1, 1'b1, 2'd2, 1'b0, 1'b0);
    chk("R8", "store no fon status", 64'(rsp_status), 64'h03);
    issue(64'h0000_0000_0000_2000, 4'd1, 1'b0, 2'd2, 1'b0, 1'b0);
    chk("R8", "load mode2 allowed", 64'(rsp_fault), 64'd0);
    issue(64'h0000_0000_0000_2000, 4'd1, 1'b1, 2'd1, 1'b0, 1'b0);
    chk("R8", "store mode1 allowed", 64'(rsp_fault), 64'd0);
  endtask

  task automatic t_fault_on();
    set_tb(1'b1, 31'h20, 4'hf, 4'hf, 1'b1, 1'b0);
    issue(64'h0000_0000_0000_4000, 4'd2, 1'b0, 2'd0, 1'b0, 1'b0);
    chk("R9", "load fault", 64'(rsp_fault), 64'd2);
    chk("R9", "load status", 64'(rsp_status), 64'h04);
    issue(64'h0000_0000_0000_4000, 4'd2, 1'b1, 2'd0, 1'b0, 1'b0);
    chk("R9", "store ignores fon-read", 64'(rsp_fault), 64'd0);
    set_tb(1'b1, 31'h20, 4'hf, 4'hf, 1'b0, 1'b1);
    issue(64'h0000_0000_0000_4000, 4'd2, 1'b1, 2'd0, 1'b0, 1'b0);
    chk("R9", "store status", 64'(rsp_status), 64'h09);
  endtask

  task automatic t_counters();
    do_reset();
    set_tb(1'b1, 31'h3, 4'hf, 4'h1, 1'b0, 1'b0);
    issue(64'h0000_0000_0000_1000, 4'd4, 1'b0, 2'd0, 1'b0, 1'b0);
    issue(64'h0000_0000_0000_1000, 4'd4, 1'b0, 2'd0, 1'b0, 1'b0);
    issue(64'h0000_0000_0000_1000, 4'd4, 1'b1, 2'd3, 1'b0, 1'b0);
    issue(64'h0000_0000_0000_1001, 4'd4, 1'b1, 2'd0, 1'b0, 1'b0);
    issue(64'hFFFF_FC00_0000_0000, 4'd8, 1'b1, 2'd0, 1'b0, 1'b0);
    issue(64'h0000_0000_0000_0010, 4'd8, 1'b0, 2'd0, 1'b1, 1'b0);
    tb_hit = 1'b0;
    issue(64'h0000_0000_0000_1000, 4'd4, 1'b0, 2'd0, 1'b0, 1'b0);
    chk("R10", "rd_acc", 64'(cnt_rd_acc), 64'd3);
    chk("R10", "rd_hit", 64'(cnt_rd_hit), 64'd3);
    chk("R10", "rd_miss", 64'(cnt_rd_miss), 64'd1);
    chk("R10", "rd_viol", 64'(cnt_rd_viol), 64'd0);
    chk("R10", "wr_acc", 64'(cnt_wr_acc), 64'd1);
    chk("R10", "wr_hit", 64'(cnt_wr_hit), 64'd1);
    chk("R10", "wr_miss", 64'(cnt_wr_miss), 64'd0);
    chk("R10", "wr_viol", 64'(cnt_wr_viol), 64'd1);
  endtask

  task automatic t_saturate();
    do_reset();
    for (int i = 0; i < 20; i++)
      issue(64'h0000_0000_0000_0100, 4'd1, 1'b0, 2'd0, 1'b1, 1'b0);
    chk("R11", "rd_hit saturated", 64'(cnt_rd_hit), 64'd15);
    chk("R11", "wr_hit untouched", 64'(cnt_wr_hit), 64'd0);
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_va = '0; req_size = 4'd1;
    req_write = 1'b0; req_mode = 2'd0; req_phys = 1'b0; req_pte = 1'b0;
    set_tb(1'b0, '0, 4'h0, 4'h0, 1'b0, 1'b0);
    t_reset();
    t_align();
    t_phys();
    t_badva();
    t_superpage();
    t_miss();
    t_hit();
    t_perm();
    t_fault_on();
    t_counters();
    t_saturate();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule